// File: doc/BRIEF.md
# Doorbell and Acknowledge Interrupt Controller

This block carries interrupt signalling between two processor cores. Toward the peer core it offers a doorbell register: a write whose data holds one or more ones makes the matching doorbell lines pulse for one clock. Toward the local core it holds a bank of acknowledge vectors. Each vector latches a pending flag when its event input fires. Each vector also has an enable bit. The enabled pending flags fold into a single interrupt line.

Software programs the enables in one of two ways. It can write the whole enable vector at once through a plain mask register, or it can set and clear single bits through write-one-to-set and write-one-to-clear registers. To service the interrupt, software reads the status register, which holds the pending flags that are also enabled. It handles the set bits starting from the lowest one, then writes those bits to the clear register. A status of zero tells software that the interrupt was spurious.

The register bus is a single-cycle interface. A write takes effect at the clock edge, and read data is returned combinationally in the same cycle.

Top module: `ipc_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, every pending flag, every enable bit, `irq_out` and `bell_out` are zero.
- R2: A one on `evt_in[n]` at a clock edge sets pending flag n. Pending flag n reads as bit n at offset 0x400. Writes to 0x400 change nothing.
- R3: Writing to 0x40C clears each pending flag whose data bit is 1. Data bits that are 0 leave their flags unchanged, and an all-ones write clears every flag.
- R4: If an event and a clear for the same vector arrive on the same edge, the flag ends up set.
- R5: Writing to 0x404 replaces the whole enable vector with the data, where 1 means enabled. A write of 0 masks every vector. Reading 0x404 returns the enable vector.
- R6: Writing to 0x500 enables each vector whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R7: Writing to 0x504 disables each vector whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R8: Reading 0x408 returns the pending flags ANDed with the enables, so it reads 0 when no enabled vector is pending.
- R9: `irq_out` is 1 exactly when the value at 0x408 is nonzero.
- R10: Writing to 0x420 drives the data bits onto `bell_out` for the single cycle that follows the write edge. After that cycle `bell_out` returns to 0.
- R11: Read data is zero in these cases: when no read is requested, at 0x40C, 0x420, 0x500 and 0x504, at any unmapped offset, and in bit positions at or above NUM_VEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| evt_in | input | NUM_VEC | Acknowledge event inputs, one per vector |
| bell_out | output | NUM_VEC | Doorbell pulses toward the peer core |
| irq_out | output | 1 | Combined interrupt to the local core |

## Verification
The bench builds the block with NUM_VEC set to 8, which makes the following checks affordable.
- It sweeps all 256 enable patterns through the mask register. Each pattern is paired with sixteen pending patterns, and every pairing checks the status value and the interrupt line against the bitwise AND the bench computes.
- The small width also leaves bits 8 to 31 unused, so the bench can check that they read as zero, including after all-ones writes.
- It runs a per-vector walk over the set, clear, enable, disable and doorbell registers.
- It covers the case where an event and a clear hit the same vector on the same edge.

// File: rtl/ipc_irq_pkg.sv
package ipc_irq_pkg;

  localparam int unsigned OFF_RAW  = 32'h400;
  localparam int unsigned OFF_MASK = 32'h404;
  localparam int unsigned OFF_STAT = 32'h408;
  localparam int unsigned OFF_CLR  = 32'h40C;
  localparam int unsigned OFF_BELL = 32'h420;
  localparam int unsigned OFF_ENA  = 32'h500;
  localparam int unsigned OFF_DIS  = 32'h504;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASK,
    SEL_STAT,
    SEL_CLR,
    SEL_BELL,
    SEL_ENA,
    SEL_DIS
  } reg_sel_e;

endpackage

// File: rtl/ipc_irq_rst_sync.sv
module ipc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ipc_irq_decode.sv
module ipc_irq_decode
  import ipc_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if      (addr == ADDR_W'(OFF_RAW))  sel = SEL_RAW;
    else if (addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
    else if (addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFF_CLR))  sel = SEL_CLR;
    else if (addr == ADDR_W'(OFF_BELL)) sel = SEL_BELL;
    else if (addr == ADDR_W'(OFF_ENA))  sel = SEL_ENA;
    else if (addr == ADDR_W'(OFF_DIS))  sel = SEL_DIS;
    else                                sel = SEL_NONE;
  end

endmodule

// File: rtl/ipc_irq_ack_bank.sv
module ipc_irq_ack_bank #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] evt_in,
  input  logic [NUM_VEC-1:0] wdata,
  input  logic               clr_we,
  input  logic               mask_we,
  input  logic               ena_we,
  input  logic               dis_we,
  output logic [NUM_VEC-1:0] raw_q,
  output logic [NUM_VEC-1:0] en_q,
  output logic [NUM_VEC-1:0] stat,
  output logic               irq
);

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    logic raw_d, raw_ce;
    logic en_d, en_ce;

    // Pending flag: event set takes priority over a clear write.
    always_comb begin
      raw_ce = evt_in[i] | (clr_we & wdata[i]);
      raw_d  = evt_in[i];
    end

    // Enable bit: whole-vector mask write, or single-bit set/clear.
    always_comb begin
      en_ce = mask_we | ((ena_we | dis_we) & wdata[i]);
      en_d  = mask_we ? wdata[i] : ena_we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw_q[i] <= 1'b0;
      else if (raw_ce) raw_q[i] <= raw_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q[i] <= 1'b0;
      else if (en_ce) en_q[i] <= en_d;
    end
  end

  assign stat = raw_q & en_q;
  assign irq  = |stat;

endmodule

// File: rtl/ipc_irq_bell.sv
module ipc_irq_bell #(
  parameter int NUM_VEC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bell_we,
  input  logic [NUM_VEC-1:0] wdata,
  output logic [NUM_VEC-1:0] bell_q
);

  logic [NUM_VEC-1:0] bell_d;
  logic               bell_ce;

  always_comb begin
    bell_ce = bell_we | (|bell_q);
    bell_d  = bell_we ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bell_q <= '0;
    else if (bell_ce) bell_q <= bell_d;
  end

endmodule

// File: rtl/ipc_irq_ctrl.sv
module ipc_irq_ctrl
  import ipc_irq_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] evt_in,
  output logic [NUM_VEC-1:0] bell_out,
  output logic               irq_out
);

  localparam int DATA_W = 32;

  logic               rst_sync_n;
  reg_sel_e           sel;
  logic               wr_go, rd_go;
  logic [NUM_VEC-1:0] wvec;
  logic [NUM_VEC-1:0] raw_q, en_q, stat;

  ipc_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ipc_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  assign wr_go = bus_en & bus_wr;
  assign rd_go = bus_en & ~bus_wr;
  assign wvec  = bus_wdata[NUM_VEC-1:0];

  ipc_irq_ack_bank #(.NUM_VEC(NUM_VEC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt_in  (evt_in),
    .wdata   (wvec),
    .clr_we  (wr_go && sel == SEL_CLR),
    .mask_we (wr_go && sel == SEL_MASK),
    .ena_we  (wr_go && sel == SEL_ENA),
    .dis_we  (wr_go && sel == SEL_DIS),
    .raw_q   (raw_q),
    .en_q    (en_q),
    .stat    (stat),
    .irq     (irq_out)
  );

  ipc_irq_bell #(.NUM_VEC(NUM_VEC)) u_bell (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .bell_we (wr_go && sel == SEL_BELL),
    .wdata   (wvec),
    .bell_q  (bell_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      case (sel)
        SEL_RAW:  bus_rdata[NUM_VEC-1:0] = raw_q;
        SEL_MASK: bus_rdata[NUM_VEC-1:0] = en_q;
        SEL_STAT: bus_rdata[NUM_VEC-1:0] = stat;
        default:  bus_rdata = {DATA_W{1'b0}};
      endcase
    end
  end

endmodule

// File: rtl/ipc_irq_ctrl_chk.sv
module ipc_irq_ctrl_chk
  import ipc_irq_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [NUM_VEC-1:0] evt_in,
  input logic [NUM_VEC-1:0] raw,
  input logic [NUM_VEC-1:0] en,
  input logic [NUM_VEC-1:0] bell_out,
  input logic               irq_out
);

  logic wr_clr, wr_ena, wr_dis, wr_bell, wr_mask;
  assign wr_clr  = bus_en && bus_wr && bus_addr == ADDR_W'(OFF_CLR);
  assign wr_ena  = bus_en && bus_wr && bus_addr == ADDR_W'(OFF_ENA);
  assign wr_dis  = bus_en && bus_wr && bus_addr == ADDR_W'(OFF_DIS);
  assign wr_bell = bus_en && bus_wr && bus_addr == ADDR_W'(OFF_BELL);
  assign wr_mask = bus_en && bus_wr && bus_addr == ADDR_W'(OFF_MASK);

  p_evt_sets_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((raw & $past(evt_in)) == $past(evt_in)));

  p_no_clear_keeps_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((raw & $past(raw)) == $past(raw)));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && evt_in != '0) |=> ((raw & $past(evt_in)) == $past(evt_in)));

  p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> ((en & $past(bus_wdata[NUM_VEC-1:0])) == $past(bus_wdata[NUM_VEC-1:0])));

  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> ((en & $past(bus_wdata[NUM_VEC-1:0])) == '0));

  p_en_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ena || wr_dis || wr_mask) |=> $stable(en));

  p_irq_needs_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (raw != '0 && en != '0));

  p_bell_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bell |=> (bell_out == '0));

endmodule

bind ipc_irq_ctrl ipc_irq_ctrl_chk #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_en    (bus_en),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .evt_in    (evt_in),
  .raw       (raw_q),
  .en        (en_q),
  .bell_out  (bell_out),
  .irq_out   (irq_out)
);

// File: tb/ipc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ipc_irq_ctrl_tb_top;

  localparam int NV = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NV-1:0] evt_in, bell_out;
  logic          irq_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  ipc_irq_ctrl #(.NUM_VEC(NV), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .bell_out(bell_out), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.5;
    d = bus_rdata;
    bus_en = 1'b0;
    #0.1;
  endtask

  task automatic pulse_evt(input logic [NV-1:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  r;
    rst_n = 1'b0; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
    check("R1 bell in reset", {24'd0, bell_out}, 32'd0);
    rd(12'h400, d); check("R1 raw in reset", d, 32'd0);
    rd(12'h404, d); check("R1 enable in reset", d, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(12'h408, d); check("R1 status after release", d, 32'd0);
    check("R1 irq after release", {31'd0, irq_out}, 32'd0);

    // R2: events set raw, raw writes ignored
    pulse_evt(8'h81);
    rd(12'h400, d); check("R2 raw after events", d, 32'h81);
    wr(12'h400, 32'hFFFF_FFFF);
    rd(12'h400, d); check("R2 raw write ignored", d, 32'h81);
    check("R9 irq with no enables", {31'd0, irq_out}, 32'd0);

    // R3: W1C with zero bits no effect, then all-ones
    wr(12'h40C, 32'h01);
    rd(12'h400, d); check("R3 partial clear", d, 32'h80);
    wr(12'h40C, 32'h00);
    rd(12'h400, d); check("R3 zero clear no effect", d, 32'h80);
    pulse_evt(8'h3C);
    wr(12'h40C, 32'hFFFF_FFFF);
    rd(12'h400, d); check("R3 all-ones clear", d, 32'h00);

    // R4: set wins over clear on the same edge
    @(negedge clk);
    evt_in = 8'h04;
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 12'h40C; bus_wdata = 32'hFF;
    @(negedge clk);
    evt_in = '0; bus_en = 1'b0; bus_wr = 1'b0;
    rd(12'h400, d); check("R4 set wins over clear", d, 32'h04);
    wr(12'h40C, 32'hFF);

    // R6/R7: enable W1S and disable W1C, per-vector walk
    wr(12'h500, 32'h05);
    rd(12'h404, d); check("R6 enable set", d, 32'h05);
    wr(12'h500, 32'h0A);
    rd(12'h404, d); check("R6 enable accumulates", d, 32'h0F);
    wr(12'h504, 32'h03);
    rd(12'h404, d); check("R7 disable clears", d, 32'h0C);
    wr(12'h504, 32'h00);
    rd(12'h404, d); check("R7 zero disable no effect", d, 32'h0C);
    wr(12'h404, 32'h00);
    for (int n = 0; n < NV; n++) begin
      wr(12'h500, 32'(1) << n);
      rd(12'h404, d); check("R6 walk enable", d, 32'(1) << n);
      pulse_evt(8'(1) << n);
      check("R9 walk irq", {31'd0, irq_out}, 32'd1);
      wr(12'h504, 32'(1) << n);
      rd(12'h404, d); check("R7 walk disable", d, 32'd0);
      check("R9 walk irq masked", {31'd0, irq_out}, 32'd0);
      wr(12'h40C, 32'(1) << n);
    end

    // R5/R8/R9: sweep all mask patterns against pending patterns
    for (int e = 0; e < 256; e++) begin
      wr(12'h404, 32'hFFFF_FF00 | 32'(e));
      rd(12'h404, d); check("R5 mask readback", d, 32'(e));
      for (int k = 0; k < 16; k++) begin
        r = 8'(k * 17 + e);
        pulse_evt(r);
        rd(12'h408, d); check("R8 status", d, 32'(r & 8'(e)));
        check("R9 irq", {31'd0, irq_out}, {31'd0, |(r & 8'(e))});
        wr(12'h40C, 32'hFF);
      end
    end
    wr(12'h404, 32'h0);
    pulse_evt(8'hFF);
    rd(12'h408, d); check("R5 zero mask masks all", d, 32'd0);
    check("R9 irq zero mask", {31'd0, irq_out}, 32'd0);

    // R10: doorbell pulses
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 12'h420; bus_wdata = 32'(1) << n;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
      check("R10 bell pulse", {24'd0, bell_out}, 32'(1) << n);
      @(negedge clk);
      check("R10 bell returns low", {24'd0, bell_out}, 32'd0);
    end

    // R11: zero reads
    wr(12'h404, 32'hFF);
    rd(12'h40C, d); check("R11 clear reads zero", d, 32'd0);
    rd(12'h420, d); check("R11 bell reads zero", d, 32'd0);
    rd(12'h500, d); check("R11 enable reads zero", d, 32'd0);
    rd(12'h504, d); check("R11 disable reads zero", d, 32'd0);
    rd(12'h000, d); check("R11 unmapped reads zero", d, 32'd0);
    rd(12'h404, d); check("R11 upper bits zero", d, 32'hFF);
    bus_addr = 12'h404; bus_en = 1'b0; #0.5;
    check("R11 idle read zero", bus_rdata, 32'd0);

    finish_run();
  end

endmodule